// File: doc/BRIEF.md
# Read Data Return Delay Equalizer

Several memory devices that share one data channel usually return read data at different round-trip latencies. This block sits on the read-data return path of one device and holds each outgoing packet for a programmable number of extra clock cycles, so that all devices on the channel line up at the controller. Valid and payload travel through the same delay stages, so a packet always leaves whole.

The extra delay is the sum of two parts. The first is a two-bit delay field that software programs to 0, 1 or 2 cycles. The second is a one-cycle skip. The skip is normally decided by an autoskip latch, which samples a timing-phase indicator when an initialization capture strobe arrives. Software can override that latch with a manual enable bit and a manual value bit.

Two small registers are reached through a simple write/read port. Reads are registered and take one cycle. A change of delay never re-times a packet that is already in flight. A longer delay applies to the next packet at once. A shorter delay waits until nothing is in flight, so two packets can never meet at the output.

Top module: `rdq_delay_eq`

## Requirements
- R1: A packet presented with in_vld high appears on out_vld/out_data exactly 1+D cycles later, where D is the total extra delay. For D=0 that is the cycle right after the input cycle, and the payload is unchanged.
- R2: D equals the delay field plus the skip cycle. The skip cycle is 1 when the selected skip source is 0, and 0 when it is 1.
- R3: The delay field is at address 0, bits [1:0]. A write whose whole data word is 0, 1 or 2 stores that value. A write with any larger word is ignored and the field keeps its old value.
- R4: The skip register is at address 1. Bit 0 is the manual value, bit 1 is the manual enable and bit 2 is the autoskip bit. All three bits are 0 after reset.
- R5: Writes to address 1 update only bits 0 and 1. The value written to bit 2 has no effect on the autoskip bit.
- R6: When init_capture is high, the autoskip bit takes the value of phase_early at that edge. While the manual enable is 0, autoskip 1 (early) adds no skip cycle and autoskip 0 adds one.
- R7: While the manual enable is 1, the manual value replaces the autoskip bit as the skip source. Enable 1 with value 1 gives the early timing (no skip cycle). The combination enable 1 with value 0 is outside the legal setting and adds one cycle.
- R8: When a register write raises D, packets that enter after the write use the new D. Packets already in flight keep their old timing.
- R9: When a register write lowers D, the lower value is adopted only in a cycle when no packet is waiting in the delay stages. Until then the old D stays in force. No packet is ever lost or emitted twice.
- R10: reg_rdata shows, one cycle after a read, the register selected by reg_addr on the previous cycle, with its value before any write made in that same cycle. Unused bits and unmapped addresses read as 0.
- R11: While reset is asserted and in the cycle after it, out_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Read packet valid from the core side |
| in_data | input | DATA_W | Read packet payload |
| init_capture | input | 1 | Initialization capture strobe for the autoskip latch |
| phase_early | input | 1 | Sampled timing-phase indicator (1 = early packet) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Registered read data |
| out_vld | output | 1 | Delayed packet valid |
| out_data | output | DATA_W | Delayed packet payload |

## Verification
The bench drives back-to-back and sparse streams under every total delay from 0 to 3. Each skip source is exercised: the autoskip latch in both phases, the legal manual override and the illegal one. A design that sums the delay wrongly, or inverts the skip sense, shifts every packet by a cycle. The bench also raises the delay in the middle of a full-rate stream, which catches designs that re-time packets already in flight. It lowers the delay under the same load, which catches designs that let an old and a new packet collide, or that drop or repeat one. Writes of out-of-range delay values and writes to the read-only autoskip bit are checked through the register readback and the output timing.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
  // register map, offsets are decoded by the register port
  localparam int ADDR_DLY  = 0;
  localparam int ADDR_SKIP = 1;
  // skip register bit positions
  localparam int SKIP_MAN_BIT  = 0;
  localparam int SKIP_EN_BIT   = 1;
  localparam int SKIP_AUTO_BIT = 2;
endpackage

// File: rtl/rdq_ctrl_regs.sv
module rdq_ctrl_regs
  import rdq_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int ADDR_W    = 2,
  parameter int FIELD_MAX = 2,
  parameter int FW        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              init_capture,
  input  logic              phase_early,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [FW-1:0]     dly_q,
  output logic              man_val,
  output logic              man_en,
  output logic              auto_q
);
  logic hit_dly, hit_skip, dly_ok;
  logic [REG_W-1:0] rd_mux;

  assign hit_dly  = (reg_addr == ADDR_W'(ADDR_DLY));
  assign hit_skip = (reg_addr == ADDR_W'(ADDR_SKIP));
  assign dly_ok   = (reg_wdata <= REG_W'(FIELD_MAX));

  // delay field carries no reset value: software programs it first
  always_ff @(posedge clk) begin
    if (reg_wr && hit_dly && dly_ok)
      dly_q <= reg_wdata[FW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      man_val <= 1'b0;
      man_en  <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      if (reg_wr && hit_skip) begin
        man_val <= reg_wdata[SKIP_MAN_BIT];
        man_en  <= reg_wdata[SKIP_EN_BIT];
      end
      if (init_capture)
        auto_q <= phase_early;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_dly) begin
      rd_mux[FW-1:0] = dly_q;
    end else if (hit_skip) begin
      rd_mux[SKIP_MAN_BIT]  = man_val;
      rd_mux[SKIP_EN_BIT]   = man_en;
      rd_mux[SKIP_AUTO_BIT] = auto_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/rdq_skip_sel.sv
module rdq_skip_sel #(
  parameter int FW = 2,
  parameter int DW = 2
) (
  input  logic [FW-1:0] dly_q,
  input  logic          man_en,
  input  logic          man_val,
  input  logic          auto_q,
  output logic [DW-1:0] d_req
);
  logic early;
  assign early = man_en ? man_val : auto_q;
  assign d_req = DW'(dly_q) + DW'(!early);
endmodule

// File: rtl/rdq_tap_pipe.sv
module rdq_tap_pipe #(
  parameter int DATA_W = 32,
  parameter int MAXD   = 3,
  parameter int DW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DW-1:0]     d_req,
  output logic [DW-1:0]     d_eff,
  output logic              head_vld,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  // slot i hands its packet to the output register after i+1 edges
  logic              sl_v  [MAXD];
  logic [DATA_W-1:0] sl_d  [MAXD];
  logic              nx_v  [MAXD];
  logic [DATA_W-1:0] nx_d  [MAXD];
  logic [MAXD-1:0]   occ;
  logic [DW-1:0]     d_app;
  logic              busy, direct;

  genvar i;
  generate
    for (i = 0; i < MAXD; i++) begin : g_slot
      logic take;
      assign occ[i] = sl_v[i];
      assign take   = in_vld && (d_eff == DW'(i + 1));
      if (i == MAXD - 1) begin : g_top
        assign nx_v[i] = take;
        assign nx_d[i] = in_data;
      end else begin : g_mid
        assign nx_v[i] = take || sl_v[i+1];
        assign nx_d[i] = take ? in_data : sl_d[i+1];
      end
    end
  endgenerate

  assign busy     = |occ;
  assign head_vld = sl_v[0];
  // raise at once, lower only once the stages are empty
  assign d_eff    = (!busy || d_req >= d_app) ? d_req : d_app;
  assign direct   = in_vld && (d_eff == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      d_app   <= '0;
      out_vld <= 1'b0;
      for (int k = 0; k < MAXD; k++) sl_v[k] <= 1'b0;
    end else begin
      d_app   <= d_eff;
      out_vld <= direct || sl_v[0];
      for (int k = 0; k < MAXD; k++) sl_v[k] <= nx_v[k];
    end
  end

  always_ff @(posedge clk) begin
    out_data <= direct ? in_data : sl_d[0];
    for (int k = 0; k < MAXD; k++) sl_d[k] <= nx_d[k];
  end
endmodule

// File: rtl/rdq_delay_eq.sv
module rdq_delay_eq #(
  parameter int DATA_W    = 32,
  parameter int REG_W     = 8,
  parameter int ADDR_W    = 2,
  parameter int FIELD_MAX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic              init_capture,
  input  logic              phase_early,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  localparam int FW   = $clog2(FIELD_MAX + 1);
  localparam int MAXD = FIELD_MAX + 1;
  localparam int DW   = $clog2(MAXD + 1);

  logic [FW-1:0] dly_q;
  logic          man_val, man_en, auto_q;
  logic [DW-1:0] d_req, d_eff;
  logic          head_vld;

  rdq_ctrl_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .FIELD_MAX(FIELD_MAX), .FW(FW)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .init_capture(init_capture), .phase_early(phase_early), .reg_rdata(reg_rdata),
    .dly_q(dly_q), .man_val(man_val), .man_en(man_en), .auto_q(auto_q)
  );

  rdq_skip_sel #(.FW(FW), .DW(DW)) sel_i (
    .dly_q(dly_q), .man_en(man_en), .man_val(man_val), .auto_q(auto_q), .d_req(d_req)
  );

  rdq_tap_pipe #(.DATA_W(DATA_W), .MAXD(MAXD), .DW(DW)) pipe_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .d_req(d_req),
    .d_eff(d_eff), .head_vld(head_vld), .out_vld(out_vld), .out_data(out_data)
  );
endmodule

// File: rtl/rdq_delay_eq_chk.sv
module rdq_delay_eq_chk #(
  parameter int DATA_W    = 32,
  parameter int REG_W     = 8,
  parameter int ADDR_W    = 2,
  parameter int FIELD_MAX = 2,
  parameter int FW        = 2,
  parameter int DW        = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [DATA_W-1:0] in_data,
  input logic              init_capture,
  input logic              phase_early,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_data,
  input logic [FW-1:0]     dly_q,
  input logic              auto_q,
  input logic [DW-1:0]     d_eff,
  input logic              head_vld
);
  // R3
  big_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(0) && reg_wdata > REG_W'(FIELD_MAX)) |=> $stable(dly_q));

  // R5
  auto_readonly_chk: assert property (@(posedge clk) disable iff (rst)
    !init_capture |=> $stable(auto_q));

  // R6
  auto_capture_chk: assert property (@(posedge clk) disable iff (rst)
    init_capture |=> (auto_q == $past(phase_early)));

  // R1
  zero_delay_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && d_eff == '0) |=> (out_vld && out_data == $past(in_data)));

  // R9
  no_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && d_eff == '0) |-> !head_vld);

  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_vld);
endmodule

bind rdq_delay_eq rdq_delay_eq_chk #(
  .DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .FIELD_MAX(FIELD_MAX), .FW(FW), .DW(DW)
) chk_i (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .init_capture(init_capture),
  .phase_early(phase_early), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .out_vld(out_vld), .out_data(out_data), .dly_q(dly_q), .auto_q(auto_q), .d_eff(d_eff),
  .head_vld(head_vld)
);

// File: tb/rdq_delay_eq_tb_top.sv
module rdq_delay_eq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] in_data = '0;
  logic        init_capture = 1'b0;
  logic        phase_early = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        out_vld;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  rdq_delay_eq dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .init_capture(init_capture),
    .phase_early(phase_early), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .out_vld(out_vld), .out_data(out_data)
  );

  typedef struct { int due; logic [31:0] d; } pkt_t;
  pkt_t q[$];
  int   cyc = 0;
  int   m_dly = 0, m_dapp = 0;
  bit   m_auto = 0, m_en = 0, m_man = 0;
  bit   exp_vld = 0;
  logic [31:0] exp_data = '0;
  logic [7:0]  exp_rdata = '0;
  int   n_cmp = 0, n_bad = 0;
  string cur_req = "R11";
  bit   done = 0;
  int   dreq, deff, hits, hidx;
  bit   busy;

  // behavioural reference: each packet gets a due edge index
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_auto = 0; m_en = 0; m_man = 0; m_dapp = 0;
      exp_vld = 0; exp_rdata = '0;
    end else begin
      busy = (q.size() != 0);
      dreq = m_dly + ((m_en ? m_man : m_auto) ? 0 : 1);
      deff = (!busy || dreq >= m_dapp) ? dreq : m_dapp;
      m_dapp = deff;
      if (in_vld) q.push_back('{cyc + deff, in_data});
      hits = 0; hidx = -1;
      for (int i = 0; i < q.size(); i++)
        if (q[i].due == cyc) begin hits++; if (hidx < 0) hidx = i; end
      if (hits > 1) begin
        n_bad++;
        $display("FAIL R9: model saw %0d packets due at one edge, expected 1", hits);
      end
      exp_vld = (hidx >= 0);
      if (hidx >= 0) begin exp_data = q[hidx].d; q.delete(hidx); end
      case (reg_addr)
        2'd0: exp_rdata = 8'(m_dly);
        2'd1: exp_rdata = {5'd0, m_auto, m_en, m_man};
        default: exp_rdata = 8'd0;
      endcase
      if (reg_wr && reg_addr == 2'd0 && reg_wdata <= 8'd2) m_dly = int'(reg_wdata);
      if (reg_wr && reg_addr == 2'd1) begin m_man = reg_wdata[0]; m_en = reg_wdata[1]; end
      if (init_capture) m_auto = phase_early;
    end
    cyc++;
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (out_vld !== exp_vld) begin
        n_bad++;
        $display("FAIL %s: out_vld got %0b expected %0b (cycle %0d)", cur_req, out_vld, exp_vld, cyc);
      end else if (exp_vld && out_data !== exp_data) begin
        n_bad++;
        $display("FAIL %s: out_data got %h expected %h", cur_req, out_data, exp_data);
      end
      if (!rst) begin
        n_cmp++;
        if (reg_rdata !== exp_rdata) begin
          n_bad++;
          $display("FAIL R10 (%s): reg_rdata got %h expected %h", cur_req, reg_rdata, exp_rdata);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic capture(input logic ph);
    @(negedge clk); init_capture = 1'b1; phase_early = ph;
    @(negedge clk); init_capture = 1'b0;
  endtask

  task automatic stream(input int n, input int dens, input int wr_at,
                        input logic [1:0] wa, input logic [7:0] wv);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_vld  = ($urandom % 100) < dens;
      in_data = $urandom;
      reg_wr  = (k == wr_at);
      if (k == wr_at) begin reg_addr = wa; reg_wdata = wv; end
    end
    @(negedge clk); in_vld = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R11: quiet output during and right after reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    cur_req = "R4";  idle(2);                        // R4 reset value of skip register
    cur_req = "R3";  wr(2'd0, 8'd0); wr(2'd0, 8'd3); // R3 value 3 ignored
    idle(1); wr(2'd0, 8'd7); idle(2);
    cur_req = "R2";  stream(30, 60, -1, 0, 0); idle(6);   // R2 field 0 plus skip 1
    cur_req = "R5";  wr(2'd1, 8'h04); idle(2);       // R5 bit 2 write has no effect
    stream(20, 50, -1, 0, 0); idle(6);
    cur_req = "R6";  capture(1'b1); idle(1);         // R6 early phase, no skip
    stream(30, 70, -1, 0, 0); idle(6);
    wr(2'd0, 8'd2); stream(30, 70, -1, 0, 0); idle(6);
    capture(1'b0); stream(30, 70, -1, 0, 0); idle(6);
    cur_req = "R7";  wr(2'd1, 8'h03);                // R7 legal override: early
    stream(30, 70, -1, 0, 0); idle(6);
    wr(2'd1, 8'h02); stream(30, 70, -1, 0, 0); idle(6);
    cur_req = "R1";  wr(2'd0, 8'd0); wr(2'd1, 8'h03);  // R1 zero delay full rate
    stream(40, 100, -1, 0, 0); idle(6);
    cur_req = "R8";  stream(40, 100, 10, 2'd0, 8'd2); idle(6);  // R8 raise mid stream
    cur_req = "R9";  stream(40, 100, 10, 2'd0, 8'd0); idle(2); // R9 lower mid stream
    stream(40, 60, 5, 2'd0, 8'd2); idle(1);
    stream(40, 60, 8, 2'd0, 8'd1); idle(6);
    cur_req = "R10"; reg_addr = 2'd2; idle(3); reg_addr = 2'd0; idle(3);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule